// File: doc/BRIEF.md
# I2C Three-Bus Broadcast Register Writer

This block is an I2C master engine that takes one register-write request at a time from a local capture port and plays it out on three independent downstream I2C buses at once. Every bus sees the same frame on the same clock cycles. A request carries a 7-bit device address, a 16-bit register address and a 16-bit data word. Each request carries its full register address, so consecutive writes may target unrelated registers. A request is forwarded as soon as it is accepted; no queue of requests is kept.

The engine drives each bus through open-drain enables: a 1 pulls the line low and a 0 releases it. It samples the returned SDA level of each bus to collect the acknowledge after every byte. While a forward is in flight, the `hold` output is high. An upstream I2C slave front end uses it to stretch SCL toward its own master until the write has reached all three devices. A one-cycle `done` pulse then reports which buses acknowledged the whole frame.

Top module: `i2c_tri_bcast_writer`

## Requirements
- R1: `req_ready` is high exactly when no frame is in flight. A request is taken on a cycle with `req_valid` and `req_ready` both high. `hold` is high from the next cycle until the cycle in which `done` pulses, when it falls. `req_valid` raised while `hold` is high starts nothing.
- R2: Each frame is START, then five bytes: `{req_dev, 1'b0}` (write), register address high byte, register address low byte, data high byte, data low byte, then STOP. Every byte goes MSB first and is followed by a ninth clock for the acknowledge.
- R3: When every bus acknowledges, the three buses carry identical SCL and SDA drive on every cycle of the frame.
- R4: One bit takes four phases of `div_q`+1 clock cycles each, and START and STOP take one bit time each. `done` therefore goes high 188×(`div_q`+1) clock cycles after the accepting edge.
- R5: Whenever `hold` is low, every `scl_oe` and `sda_oe` bit is 0 (all lines released).
- R6: Within a frame, SDA on a bus changes only while its SCL is low. The only exceptions are the START (SDA falls while SCL is high) and the STOP (SDA rises while SCL is high).
- R7: Bus i acknowledges a byte when `sda_in[i]` is low while SCL is high in the ninth clock. `done_ack[i]` is 1 only if bus i acknowledged all five bytes.
- R8: A bus that does not acknowledge a byte issues a STOP in the next bit time and then keeps both its lines released for the rest of the frame, while the other buses finish the full frame. Its `err_sticky[i]` bit goes to 1 and stays 1 until reset.
- R9: `done` is high for exactly one cycle per accepted request, and `done_ack` is valid in that cycle.
- R10: `div_q` is captured when a request is accepted; changing it during a frame does not alter that frame's timing.
- R11: After reset, `req_ready`=1, `hold`=0, `done`=0, `err_sticky`=0, and all lines are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_dev | input | 7 | Target device address |
| req_reg | input | 16 | Target register address |
| req_data | input | 16 | Register value to write |
| div_q | input | DIV_W | Quarter-bit length minus one, in clock cycles |
| hold | output | 1 | Forward in flight; upstream should stretch its SCL |
| done | output | 1 | One-cycle end-of-frame pulse |
| done_ack | output | N_BUS | Per bus: 1 = all five bytes acknowledged |
| err_sticky | output | N_BUS | Per bus: a NACK has been seen since reset |
| scl_oe | output | N_BUS | Per bus: 1 = pull SCL low |
| sda_oe | output | N_BUS | Per bus: 1 = pull SDA low |
| sda_in | input | N_BUS | Per bus: sensed SDA level |

## Verification
The checker watches, on every cycle, the relationships visible at the handshake and status ports. It checks that an accepted request raises `hold`, that `hold` only falls together with `done`, and that `done` is a single-cycle pulse. It also checks that every line is released while idle, that a missing acknowledge always shows up as a sticky error, and that error bits never clear. The content and order of the bytes on each wire, the START/STOP framing, and lockstep across the buses need the bench's bus models to decode the lines. The same holds for per-bus STOP after a NACK, exact frame duration and divider capture. Only the scenarios can show these.

// File: rtl/i2c_bcast_pkg.sv
package i2c_bcast_pkg;

    localparam int FRAME_BYTES = 5;
    localparam int ACK_SLOT    = 8;

    typedef enum logic [1:0] {
        SL_IDLE  = 2'd0,
        SL_START = 2'd1,
        SL_BIT   = 2'd2,
        SL_STOP  = 2'd3
    } slot_e;

    typedef enum logic [1:0] {
        LN_RUN      = 2'd0,
        LN_STOPPING = 2'd1,
        LN_PARKED   = 2'd2
    } lane_mode_e;

    typedef struct packed {
        logic [6:0]  dev_addr;
        logic [15:0] reg_addr;
        logic [15:0] wr_data;
    } wr_req_t;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } pins_t;

    // Byte order on the wire: device+write, reg hi, reg lo, data hi, data lo.
    function automatic logic [7:0] frame_byte(wr_req_t r, logic [2:0] idx);
        case (idx)
            3'd0:    return {r.dev_addr, 1'b0};
            3'd1:    return r.reg_addr[15:8];
            3'd2:    return r.reg_addr[7:0];
            3'd3:    return r.wr_data[15:8];
            default: return r.wr_data[7:0];
        endcase
    endfunction

    // Line drive for one quarter phase of a slot. Phases 0,1 have SCL low,
    // phases 2,3 have SCL released. SDA moves in phase 1 for data bits.
    function automatic pins_t slot_drive(slot_e k, logic [1:0] ph, logic tx, logic sda_prev);
        pins_t p;
        p.scl_low = 1'b0;
        p.sda_low = 1'b0;
        case (k)
            SL_START: p.sda_low = ph[1];
            SL_BIT: begin
                p.scl_low = !ph[1];
                p.sda_low = (ph == 2'd0) ? sda_prev : !tx;
            end
            SL_STOP: begin
                p.scl_low = !ph[1];
                p.sda_low = (ph == 2'd0) ? sda_prev : (ph != 2'd3);
            end
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/i2c_bcast_tick.sv
module i2c_bcast_tick #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] div_in,
    output logic             step
);
    logic [DIV_W-1:0] div_r;
    logic [DIV_W-1:0] cnt_r;

    assign step = run && (cnt_r == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_r <= '0;
            cnt_r <= '0;
        end else if (load) begin
            div_r <= div_in;
            cnt_r <= div_in;
        end else if (run) begin
            cnt_r <= (cnt_r == '0) ? div_r : cnt_r - 1'b1;
        end
    end
endmodule

// File: rtl/i2c_bcast_seq.sv
module i2c_bcast_seq
    import i2c_bcast_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  wr_req_t    req_in,
    input  logic       step,
    output logic       req_ready,
    output logic       busy,
    output logic       start_frame,
    output slot_e      nxt_kind,
    output logic [1:0] nxt_ph,
    output logic       nxt_bit,
    output logic       samp_ack,
    output logic       finish
);
    logic       busy_r;
    slot_e      kind_r;
    logic [1:0] ph_r;
    logic [2:0] byte_r;
    logic [3:0] bit_r;
    wr_req_t    req_r;

    slot_e      n_kind;
    logic [2:0] n_byte;
    logic [3:0] n_bit;
    logic [7:0] cur_byte;

    assign busy        = busy_r;
    assign req_ready   = !busy_r;
    assign start_frame = req_valid && !busy_r;
    assign samp_ack    = step && kind_r == SL_BIT && ph_r == 2'd3 && bit_r == 4'(ACK_SLOT);
    assign finish      = step && kind_r == SL_STOP && ph_r == 2'd3;

    always_comb begin
        n_kind = kind_r;
        nxt_ph = ph_r + 2'd1;
        n_byte = byte_r;
        n_bit  = bit_r;
        if (ph_r == 2'd3) begin
            case (kind_r)
                SL_START: begin
                    n_kind = SL_BIT;
                    n_byte = '0;
                    n_bit  = '0;
                end
                SL_BIT: begin
                    if (bit_r != 4'(ACK_SLOT)) begin
                        n_bit = bit_r + 4'd1;
                    end else begin
                        n_bit = '0;
                        if (byte_r == 3'(FRAME_BYTES - 1)) n_kind = SL_STOP;
                        else n_byte = byte_r + 3'd1;
                    end
                end
                default: n_kind = SL_IDLE;
            endcase
        end
        cur_byte = frame_byte(req_r, n_byte);
        nxt_kind = n_kind;
        nxt_bit  = (n_bit == 4'(ACK_SLOT)) ? 1'b1 : cur_byte[3'd7 - n_bit[2:0]];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_r <= 1'b0;
            kind_r <= SL_IDLE;
            ph_r   <= '0;
            byte_r <= '0;
            bit_r  <= '0;
            req_r  <= '0;
        end else if (start_frame) begin
            busy_r <= 1'b1;
            kind_r <= SL_START;
            ph_r   <= '0;
            byte_r <= '0;
            bit_r  <= '0;
            req_r  <= req_in;
        end else if (step) begin
            kind_r <= n_kind;
            ph_r   <= nxt_ph;
            byte_r <= n_byte;
            bit_r  <= n_bit;
            if (finish) busy_r <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_bcast_lane.sv
module i2c_bcast_lane
    import i2c_bcast_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_frame,
    input  logic       step,
    input  slot_e      nxt_kind,
    input  logic [1:0] nxt_ph,
    input  logic       nxt_bit,
    input  logic       samp_ack,
    input  logic       sda_in,
    output logic       scl_low,
    output logic       sda_low,
    output logic       acked,
    output logic       err
);
    lane_mode_e mode_r, mode_n;
    pins_t      pins_r, pins_n;
    slot_e      eff_kind;
    logic       nack_now;

    assign nack_now = samp_ack && mode_r == LN_RUN && sda_in;
    assign scl_low  = pins_r.scl_low;
    assign sda_low  = pins_r.sda_low;

    always_comb begin
        mode_n = mode_r;
        if (nack_now) mode_n = LN_STOPPING;
        else if (mode_r == LN_STOPPING && nxt_ph == 2'd0) mode_n = LN_PARKED;
        case (mode_n)
            LN_RUN:      eff_kind = nxt_kind;
            LN_STOPPING: eff_kind = SL_STOP;
            default:     eff_kind = SL_IDLE;
        endcase
        pins_n = slot_drive(eff_kind, nxt_ph, nxt_bit, pins_r.sda_low);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_r <= LN_RUN;
            pins_r <= '0;
            acked  <= 1'b0;
            err    <= 1'b0;
        end else if (start_frame) begin
            mode_r <= LN_RUN;
            acked  <= 1'b1;
        end else if (step) begin
            mode_r <= mode_n;
            pins_r <= pins_n;
            if (nack_now) begin
                acked <= 1'b0;
                err   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_tri_bcast_writer.sv
module i2c_tri_bcast_writer
    import i2c_bcast_pkg::*;
#(
    parameter int N_BUS = 3,
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [6:0]       req_dev,
    input  logic [15:0]      req_reg,
    input  logic [15:0]      req_data,
    input  logic [DIV_W-1:0] div_q,
    output logic             hold,
    output logic             done,
    output logic [N_BUS-1:0] done_ack,
    output logic [N_BUS-1:0] err_sticky,
    output logic [N_BUS-1:0] scl_oe,
    output logic [N_BUS-1:0] sda_oe,
    input  logic [N_BUS-1:0] sda_in
);
    wr_req_t          req_in;
    logic             busy, start_frame, step, samp_ack, finish, nxt_bit;
    slot_e            nxt_kind;
    logic [1:0]       nxt_ph;
    logic [N_BUS-1:0] acked_v;

    assign req_in = '{dev_addr: req_dev, reg_addr: req_reg, wr_data: req_data};
    assign hold   = busy;

    i2c_bcast_tick #(.DIV_W(DIV_W)) tick_i (
        .clk(clk), .rst(rst), .load(start_frame), .run(busy),
        .div_in(div_q), .step(step)
    );

    i2c_bcast_seq seq_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_in(req_in),
        .step(step), .req_ready(req_ready), .busy(busy),
        .start_frame(start_frame), .nxt_kind(nxt_kind), .nxt_ph(nxt_ph),
        .nxt_bit(nxt_bit), .samp_ack(samp_ack), .finish(finish)
    );

    for (genvar b = 0; b < N_BUS; b++) begin : g_lane
        i2c_bcast_lane lane_i (
            .clk(clk), .rst(rst), .start_frame(start_frame), .step(step),
            .nxt_kind(nxt_kind), .nxt_ph(nxt_ph), .nxt_bit(nxt_bit),
            .samp_ack(samp_ack), .sda_in(sda_in[b]),
            .scl_low(scl_oe[b]), .sda_low(sda_oe[b]),
            .acked(acked_v[b]), .err(err_sticky[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done     <= 1'b0;
            done_ack <= '0;
        end else begin
            done <= finish;
            if (finish) done_ack <= acked_v;
        end
    end
endmodule

// File: rtl/i2c_bcast_chk.sv
module i2c_bcast_chk #(
    parameter int N_BUS = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             hold,
    input logic             done,
    input logic [N_BUS-1:0] done_ack,
    input logic [N_BUS-1:0] err_sticky,
    input logic [N_BUS-1:0] scl_oe,
    input logic [N_BUS-1:0] sda_oe
);
    assert_accept_holds_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> hold);

    assert_hold_ends_with_done_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(hold) |-> done);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_follows_work_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(hold) && !hold));

    assert_idle_released_R5: assert property (@(posedge clk) disable iff (rst)
        !hold |-> (scl_oe == '0 && sda_oe == '0));

    assert_nack_flagged_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (&(done_ack | err_sticky)));

    for (genvar i = 0; i < N_BUS; i++) begin : g_bus
        assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
            !$fell(err_sticky[i]));
    end
endmodule

bind i2c_tri_bcast_writer i2c_bcast_chk #(.N_BUS(N_BUS)) chk_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .hold(hold), .done(done), .done_ack(done_ack), .err_sticky(err_sticky),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/i2c_tri_bcast_writer_tb_top.sv
module i2c_tb_slave (
    input  logic        scl,
    input  logic        sda,
    input  logic [2:0]  nack_at,
    output logic        pull,
    output logic [39:0] rx_flat,
    output int          nbytes,
    output int          nframes,
    output int          nbad
);
    logic        scl_p = 1'b1;
    logic        sda_p = 1'b1;
    logic        in_frame = 1'b0;
    logic        pull_r = 1'b0;
    logic [39:0] rx_r = '0;
    logic [7:0]  sh = '0;
    int          bitc = 0;
    int          nb = 0;
    int          nf = 0;
    int          bad = 0;

    assign pull    = pull_r;
    assign rx_flat = rx_r;
    assign nbytes  = nb;
    assign nframes = nf;
    assign nbad    = bad;

    always begin
        @(scl or sda);
        if (scl_p && scl && sda_p && !sda) begin
            if (in_frame) bad++;
            in_frame = 1'b1;
            bitc = 0;
            nb = 0;
            rx_r = '0;
            pull_r = 1'b0;
        end else if (scl_p && scl && !sda_p && sda) begin
            if (in_frame) nf++;
            in_frame = 1'b0;
            pull_r = 1'b0;
        end else if (!scl_p && scl && in_frame) begin
            if (bitc < 8) begin
                sh = {sh[6:0], sda};
                bitc++;
                if (bitc == 8 && nb < 5) rx_r[8*(4-nb) +: 8] = sh;
            end else begin
                bitc = 0;
                nb++;
            end
        end else if (scl_p && !scl && in_frame) begin
            pull_r = (bitc == 8) && (nb != int'(nack_at));
        end
        scl_p = scl;
        sda_p = sda;
    end
endmodule

module i2c_tri_bcast_writer_tb_top;
    localparam int N_BUS = 3;
    localparam int DIV_W = 12;
    localparam logic [8:0] ALL_ACK = 9'b111_111_111;

    typedef struct packed {
        logic [6:0]       dev;
        logic [15:0]      ra;
        logic [15:0]      wd;
        logic [DIV_W-1:0] div;
        logic [8:0]       nack;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [6:0] req_dev = '0;
    logic [15:0] req_reg = '0;
    logic [15:0] req_data = '0;
    logic [DIV_W-1:0] div_q = 12'd1;
    logic hold, done;
    logic [N_BUS-1:0] done_ack, err_sticky, scl_oe, sda_oe, sda_in;
    logic [N_BUS-1:0] pull, scl_line, sda_line;
    logic [2:0] nack_cfg [N_BUS];
    logic [39:0] rx [N_BUS];
    int nb [N_BUS];
    int nf [N_BUS];
    int nbad [N_BUS];

    exp_t q [$];
    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int acc_cyc = 0;
    int lock_bad = 0;
    logic all_ack_frame = 1'b1;

    always #5 clk = ~clk;

    i2c_tri_bcast_writer #(.N_BUS(N_BUS), .DIV_W(DIV_W)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_dev(req_dev), .req_reg(req_reg), .req_data(req_data), .div_q(div_q),
        .hold(hold), .done(done), .done_ack(done_ack), .err_sticky(err_sticky),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
    );

    assign scl_line = ~scl_oe;
    assign sda_line = ~(sda_oe | pull);
    assign sda_in   = sda_line;

    for (genvar g = 0; g < N_BUS; g++) begin : g_slave
        i2c_tb_slave slave_i (
            .scl(scl_line[g]), .sda(sda_line[g]), .nack_at(nack_cfg[g]),
            .pull(pull[g]), .rx_flat(rx[g]), .nbytes(nb[g]),
            .nframes(nf[g]), .nbad(nbad[g])
        );
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (req_valid && req_ready) acc_cyc <= cyc;
    end

    always @(negedge clk) begin
        if (hold && all_ack_frame &&
            ((scl_oe != '0 && scl_oe != '1) || (sda_oe != '0 && sda_oe != '1)))
            lock_bad <= lock_bad + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [6:0] dev, input logic [15:0] ra, input logic [15:0] wd,
                        input logic [DIV_W-1:0] dv, input logic [8:0] nk);
        exp_t e;
        while (!req_ready) @(negedge clk);
        for (int i = 0; i < N_BUS; i++) nack_cfg[i] = nk[3*i +: 3];
        all_ack_frame = (nk == ALL_ACK);
        div_q = dv;
        req_dev = dev;
        req_reg = ra;
        req_data = wd;
        req_valid = 1'b1;
        e = '{dev: dev, ra: ra, wd: wd, div: dv, nack: nk};
        q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        check(hold && !req_ready, "R1", "hold/ready after accept", {hold, req_ready}, 2'b10);
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (!done) @(negedge clk);
    endtask

    initial begin : monitor
        exp_t e;
        int prev_nf [N_BUS];
        int prev_lock;
        int nk, exp_nb, exp_cyc;
        logic [7:0] eb [5];
        logic [N_BUS-1:0] exp_ack;
        logic [N_BUS-1:0] exp_err;
        for (int i = 0; i < N_BUS; i++) prev_nf[i] = 0;
        prev_lock = 0;
        exp_err = '0;
        forever begin
            @(negedge clk);
            if (done) begin
                if (q.size() == 0) begin
                    check(0, "R1", "done without accepted request", 1, 0);
                end else begin
                    e = q.pop_front();
                    eb[0] = {e.dev, 1'b0};
                    eb[1] = e.ra[15:8];
                    eb[2] = e.ra[7:0];
                    eb[3] = e.wd[15:8];
                    eb[4] = e.wd[7:0];
                    exp_cyc = 188 * (int'(e.div) + 1) + 1;
                    check(cyc - acc_cyc == exp_cyc, "R4/R10", "accept-to-done cycles",
                          cyc - acc_cyc, exp_cyc);
                    check(!hold && req_ready, "R1", "hold low in done cycle",
                          {hold, req_ready}, 2'b01);
                    check(scl_oe == '0 && sda_oe == '0, "R5", "lines released at done",
                          {scl_oe, sda_oe}, 0);
                    for (int i = 0; i < N_BUS; i++) begin
                        nk = int'(e.nack[3*i +: 3]);
                        exp_ack[i] = (nk > 4);
                        exp_nb = (nk > 4) ? 5 : nk + 1;
                        check(nf[i] == prev_nf[i] + 1, "R8", "frames closed by STOP on bus",
                              nf[i], prev_nf[i] + 1);
                        prev_nf[i] = nf[i];
                        check(nb[i] == exp_nb, "R8", "bytes before STOP on bus", nb[i], exp_nb);
                        check(nbad[i] == 0, "R6", "repeated START / SDA move with SCL high",
                              nbad[i], 0);
                        for (int k = 0; k < 5; k++) begin
                            if (k < exp_nb)
                                check(rx[i][8*(4-k) +: 8] == eb[k], "R2", "byte on bus",
                                      rx[i][8*(4-k) +: 8], eb[k]);
                        end
                    end
                    exp_err = exp_err | ~exp_ack;
                    check(done_ack == exp_ack, "R7", "done_ack", done_ack, exp_ack);
                    check(err_sticky == exp_err, "R8", "err_sticky", err_sticky, exp_err);
                    if (e.nack == ALL_ACK)
                        check(lock_bad == prev_lock, "R3", "lockstep mismatch cycles",
                              lock_bad - prev_lock, 0);
                    prev_lock = lock_bad;
                end
                @(negedge clk);
                check(!done, "R9", "done width", done, 0);
            end
        end
    end

    initial begin : main
        for (int i = 0; i < N_BUS; i++) nack_cfg[i] = 3'd7;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(req_ready && !hold && !done, "R11", "reset handshake state",
              {req_ready, hold, done}, 3'b100);
        check(err_sticky == '0, "R11", "reset err_sticky", err_sticky, 0);
        check(scl_oe == '0 && sda_oe == '0, "R11", "reset lines", {scl_oe, sda_oe}, 0);
        rst = 1'b0;
        @(negedge clk);

        // all buses ACK, plus a request offered while busy
        send(7'h3A, 16'h1234, 16'hABCD, 12'd1, ALL_ACK);
        repeat (10) @(negedge clk);
        req_dev = 7'h11;
        req_reg = 16'h5555;
        req_valid = 1'b1;
        repeat (20) @(negedge clk);
        check(!req_ready && hold, "R1", "request ignored while busy",
              {req_ready, hold}, 2'b01);
        req_valid = 1'b0;
        wait_done();

        // minimum divider
        send(7'h55, 16'h0F01, 16'h8000, 12'd0, ALL_ACK);
        wait_done();

        // unrelated register address, divider changed mid-frame
        send(7'h01, 16'h7FFE, 16'h0001, 12'd3, ALL_ACK);
        repeat (40) @(negedge clk);
        div_q = 12'd0;
        wait_done();

        // bus 1 rejects the address byte
        send(7'h3A, 16'h2000, 16'h00FF, 12'd1, {3'd7, 3'd0, 3'd7});
        wait_done();

        // bus 0 rejects reg low, bus 2 rejects the last data byte
        send(7'h7F, 16'hC0DE, 16'hBEEF, 12'd2, {3'd4, 3'd7, 3'd2});
        wait_done();

        // clean frame after errors: status all acked, errors kept
        send(7'h22, 16'h0100, 16'h5A5A, 12'd1, ALL_ACK);
        wait_done();

        // every bus rejects the address
        send(7'h00, 16'hFFFF, 16'h0000, 12'd0, 9'b000_000_000);
        wait_done();

        repeat (5) @(negedge clk);
        check(q.size() == 0, "R9", "outstanding expected frames", q.size(), 0);
        check(!hold && scl_oe == '0 && sda_oe == '0, "R5", "idle after run",
              {hold, scl_oe, sda_oe}, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule